// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Engine

This block turns a target angle into its cosine and sine by a series of shift-and-add micro-rotations, one per clock, with no multiplier. A caller pulses `start` with an angle and an iteration count. The block then rotates a vector that starts on the x axis. Each step it compares the angle turned so far against the target and picks the direction of the next rotation. When the count is reached, the x register holds the cosine and the y register holds the sine.

The caller picks the iteration count for each request, and so trades accuracy against latency. The vector's start length is pre-scaled by the constant rotation gain, so no scaling is needed afterwards. Angles are signed Q2.13 radians (8192 = 1 rad) and must lie within ±π/2. Results are signed Q1.14 (16384 = 1.0).

Top module: `cordic_sincos`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are 0 and `cos_o` and `sin_o` read 0.
- R2: A `start` seen while idle makes `busy` high from the next cycle. `busy` stays high for exactly N cycles, where N is the effective iteration count. `done` is then high for one cycle, with `busy` already low.
- R3: The effective count N is `iter_n`, except that 0 gives 1 and any value above 29 gives 29.
- R4: Each busy cycle performs one rotation with index i = 0, 1, …: x' = x − d·(y >>> i), y' = y + d·(x >>> i), z' = z + d·atan_i. The shifts are arithmetic, and the 16-bit registers wrap. `cos_o` and `sin_o` show x and y.
- R5: d is +1 when the latched target is strictly greater, as a signed value, than the accumulated angle z. Otherwise d is −1, which includes the case of equality.
- R6: atan_i is atan(2^−i) in Q2.13, rounded to nearest: 6434 for i = 0, 3798 for i = 1, 2007 for i = 2, down to 1 for i = 13, and 0 for i = 14 to 28.
- R7: On an accepted start, x loads 9950 (0.6073 in Q1.14), y loads 0 and z loads 0, and the target is latched. So in the first busy cycle `cos_o` = 9950 and `sin_o` = 0.
- R8: For N ≥ 14 and a target within ±π/2, `cos_o` and `sin_o` at `done` are within 48 LSB of the true cosine and sine.
- R9: `start` is ignored while `busy` is high. The running request's angle, count and length are unchanged by it.
- R10: After `done`, `cos_o` and `sin_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Request strobe, taken only while idle |
| angle_i | input | 16 | Target angle, signed Q2.13 radians |
| iter_n | input | 5 | Requested number of micro-rotations |
| busy | output | 1 | High while rotations are in progress |
| done | output | 1 | One-cycle pulse after the last rotation |
| cos_o | output | 16 | x register, signed Q1.14; the cosine once done |
| sin_o | output | 16 | y register, signed Q1.14; the sine once done |

## Verification
The checker assumes that `start` and `iter_n` are sampled only on an idle cycle. Its length counter therefore holds the count latched at acceptance, and no restart can occur mid-run. The hold property assumes that an idle cycle without `start` leaves the registers untouched. The stimulus keeps every target within ±π/2, so the rotated vector never approaches the 16-bit wrap. It raises `start` during runs only to test that the pulse is ignored, and it covers the clamp values 0, 1 and 31 together with the exact-equality case of the direction rule.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cordic_state_e;

  // Map a requested rotation count onto the legal range 1..lim.
  function automatic int unsigned clamp_count(int unsigned req, int unsigned lim);
    if (req == 0)  return 1;
    if (req > lim) return lim;
    return req;
  endfunction

endpackage

// File: rtl/cordic_asr.sv
// Logarithmic arithmetic right shifter; one mux stage per shift-amount bit.
module cordic_asr #(
  parameter int W    = 16,
  parameter int SH_W = 5
) (
  input  logic signed [W-1:0]    din,
  input  logic        [SH_W-1:0] sh,
  output logic signed [W-1:0]    dout
);

  logic signed [W-1:0] stg [SH_W+1];

  assign stg[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int K = 1 << s;
    if (K >= W) begin : g_full
      assign stg[s+1] = sh[s] ? {W{stg[s][W-1]}} : stg[s];
    end else begin : g_part
      assign stg[s+1] = sh[s] ? {{K{stg[s][W-1]}}, stg[s][W-1:K]} : stg[s];
    end
  end

  assign dout = stg[SH_W];

endmodule

// File: rtl/cordic_atan_rom.sv
// Elementary rotation angles atan(2^-i), base precision Q2.13, widened by left shift.
module cordic_atan_rom #(
  parameter int ANG_W = 16,
  parameter int IDX_W = 5
) (
  input  logic        [IDX_W-1:0] idx,
  output logic signed [ANG_W-1:0] atan_o
);

  localparam int SHL = ANG_W - 16;

  logic [15:0] base;

  always_comb begin
    unique case (idx)
      IDX_W'(0):  base = 16'd6434;
      IDX_W'(1):  base = 16'd3798;
      IDX_W'(2):  base = 16'd2007;
      IDX_W'(3):  base = 16'd1019;
      IDX_W'(4):  base = 16'd511;
      IDX_W'(5):  base = 16'd256;
      IDX_W'(6):  base = 16'd128;
      IDX_W'(7):  base = 16'd64;
      IDX_W'(8):  base = 16'd32;
      IDX_W'(9):  base = 16'd16;
      IDX_W'(10): base = 16'd8;
      IDX_W'(11): base = 16'd4;
      IDX_W'(12): base = 16'd2;
      IDX_W'(13): base = 16'd1;
      default:    base = 16'd0;
    endcase
  end

  assign atan_o = ANG_W'(base) << SHL;

endmodule

// File: rtl/cordic_ctrl.sv
// Sequencer: accepts a request when idle, steps the rotation index, flags completion.
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int MAX_ITER = 29,
  parameter int IT_W     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IT_W-1:0] iter_n,
  output logic            load,
  output logic            step,
  output logic [IT_W-1:0] idx,
  output logic            busy,
  output logic            done
);

  cordic_state_e   state_q, state_d;
  logic [IT_W-1:0] idx_q, idx_d;
  logic [IT_W-1:0] last_q, last_d;
  logic            done_q, done_d;
  logic [IT_W-1:0] n_eff;

  assign n_eff = IT_W'(clamp_count(int'(iter_n), MAX_ITER));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    done_d  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_RUN;
          idx_d   = '0;
          last_d  = n_eff - IT_W'(1);
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        idx_d = idx_q + IT_W'(1);
        if (idx_q == last_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load || step) idx_q <= idx_d;
      if (load)         last_q <= last_d;
    end
  end

  assign idx  = idx_q;
  assign busy = (state_q == ST_RUN);
  assign done = done_q;

endmodule

// File: rtl/cordic_datapath.sv
// x, y and accumulated-angle registers with one micro-rotation per enabled cycle.
module cordic_datapath #(
  parameter int W     = 16,
  parameter int ANG_W = 16,
  parameter int IT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic        [IT_W-1:0]  idx,
  input  logic signed [ANG_W-1:0] angle_i,
  output logic signed [W-1:0]     x_o,
  output logic signed [W-1:0]     y_o
);

  localparam int OUT_FRAC = W - 2;
  // 0.6073 scaled into the output format, rounded to nearest
  localparam logic signed [W-1:0] X_INIT =
    W'((6073 * (1 << OUT_FRAC) + 5000) / 10000);

  logic signed [W-1:0]     x_q, x_d, y_q, y_d;
  logic signed [ANG_W-1:0] z_q, z_d, tgt_q;
  logic signed [W-1:0]     x_sh, y_sh;
  logic signed [ANG_W-1:0] at;
  logic                    dir_up;

  cordic_asr #(.W(W), .SH_W(IT_W)) u_shx (.din(x_q), .sh(idx), .dout(x_sh));
  cordic_asr #(.W(W), .SH_W(IT_W)) u_shy (.din(y_q), .sh(idx), .dout(y_sh));
  cordic_atan_rom #(.ANG_W(ANG_W), .IDX_W(IT_W)) u_rom (.idx(idx), .atan_o(at));

  assign dir_up = (tgt_q > z_q);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    z_d = z_q;
    if (load) begin
      x_d = X_INIT;
      y_d = '0;
      z_d = '0;
    end else if (step) begin
      if (dir_up) begin
        x_d = x_q - y_sh;
        y_d = y_q + x_sh;
        z_d = z_q + at;
      end else begin
        x_d = x_q + y_sh;
        y_d = y_q - x_sh;
        z_d = z_q - at;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      tgt_q <= '0;
    end else begin
      if (load || step) begin
        x_q <= x_d;
        y_q <= y_d;
        z_q <= z_d;
      end
      if (load) tgt_q <= angle_i;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int W        = 16,
  parameter int ANG_W    = 16,
  parameter int MAX_ITER = 29,
  localparam int IT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [ANG_W-1:0] angle_i,
  input  logic        [IT_W-1:0]  iter_n,
  output logic                    busy,
  output logic                    done,
  output logic signed [W-1:0]     cos_o,
  output logic signed [W-1:0]     sin_o
);

  logic            load, step;
  logic [IT_W-1:0] idx;

  cordic_ctrl #(.MAX_ITER(MAX_ITER), .IT_W(IT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_n(iter_n),
    .load(load), .step(step), .idx(idx), .busy(busy), .done(done)
  );

  cordic_datapath #(.W(W), .ANG_W(ANG_W), .IT_W(IT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .idx(idx),
    .angle_i(angle_i), .x_o(cos_o), .y_o(sin_o)
  );

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int W        = 16,
  parameter int MAX_ITER = 29,
  parameter int IT_W     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [IT_W-1:0]     iter_n,
  input logic                busy,
  input logic                done,
  input logic signed [W-1:0] cos_o,
  input logic signed [W-1:0] sin_o
);

  localparam logic signed [W-1:0] X_INIT =
    W'((6073 * (1 << (W - 2)) + 5000) / 10000);

  logic [IT_W-1:0] exp_len, run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len <= '0;
      run_len <= '0;
    end else if (start && !busy) begin
      run_len <= '0;
      if (iter_n == '0)                   exp_len <= IT_W'(1);
      else if (int'(iter_n) > MAX_ITER)   exp_len <= IT_W'(MAX_ITER);
      else                                exp_len <= iter_n;
    end else if (busy) begin
      run_len <= run_len + IT_W'(1);
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == exp_len && run_len != '0));

  p_first_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cos_o == X_INIT && sin_o == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cos_o) && $stable(sin_o)));

endmodule

bind cordic_sincos cordic_sincos_chk #(.W(W), .MAX_ITER(MAX_ITER), .IT_W(IT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iter_n(iter_n),
  .busy(busy), .done(done), .cos_o(cos_o), .sin_o(sin_o)
);

// File: tb/cordic_sincos_tb.sv
module cordic_sincos_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic signed [15:0] angle_i = '0;
  logic        [4:0]  iter_n = '0;
  logic               busy, done;
  logic signed [15:0] cos_o, sin_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cordic_sincos u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .angle_i(angle_i), .iter_n(iter_n),
    .busy(busy), .done(done), .cos_o(cos_o), .sin_o(sin_o)
  );

  // ---------------- behavioural reference ----------------
  int tbl [29];
  int mx = 0, my = 0, mz = 0, mt = 0, mi = 0, mn = 0;
  bit m_busy = 0, m_done = 0;

  initial begin
    for (int i = 0; i < 29; i++)
      tbl[i] = $rtoi($atan(1.0 / (2.0 ** i)) * 8192.0 + 0.5);
  end

  function automatic int w16(int v);
    return int'(shortint'(v));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; mx = 0; my = 0; mz = 0; mt = 0; mi = 0; mn = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        int xs, ys;
        xs = mx >>> mi;
        ys = my >>> mi;
        if (mt > mz) begin
          mx = w16(mx - ys); my = w16(my + xs); mz = w16(mz + tbl[mi]);
        end else begin
          mx = w16(mx + ys); my = w16(my - xs); mz = w16(mz - tbl[mi]);
        end
        mi++;
        if (mi == mn) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        mt = int'(angle_i);
        mn = (iter_n == 0) ? 1 : ((iter_n > 29) ? 29 : int'(iter_n));
        mi = 0; mx = 9950; my = 0; mz = 0; m_busy = 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(busy == m_busy, "R2", "busy", busy, m_busy);
    check(done == m_done, "R2", "done", done, m_done);
    check(int'(cos_o) == mx, "R4,R6", "cos", cos_o, mx);
    check(int'(sin_o) == my, "R4,R6", "sin", sin_o, my);
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // run one request; optionally pulse start again mid-run
  task automatic run_op(int ang, int n, bit poke, bit acc);
    int k = 0;
    int ne;
    ne = (n == 0) ? 1 : ((n > 29) ? 29 : n);
    @(negedge clk);
    start = 1; angle_i = 16'(ang); iter_n = 5'(n);
    @(negedge clk);
    start = 0; k = 1;
    while (!done && k < 40) begin
      if (poke && k == 2) begin start = 1; angle_i = 16'(-ang); iter_n = 5'd3; end
      else start = 0;
      @(negedge clk);
      k++;
    end
    start = 0;
    check(k == ne + 1, (n == 0 || n > 29) ? "R3" : "R2", "latency", k, ne + 1);
    if (acc) begin
      int ec, es;
      ec = $rtoi($cos(real'(ang) / 8192.0) * 16384.0);
      es = $rtoi($sin(real'(ang) / 8192.0) * 16384.0);
      check((cos_o - ec) <= 48 && (ec - cos_o) <= 48, poke ? "R9" : "R8", "cos accuracy", cos_o, ec);
      check((sin_o - es) <= 48 && (es - sin_o) <= 48, poke ? "R9" : "R8", "sin accuracy", sin_o, es);
    end
  endtask

  // first two rotations, to observe entry 0 and the direction rule
  task automatic two_steps(int ang, int exp_y2, string req);
    @(negedge clk);
    start = 1; angle_i = 16'(ang); iter_n = 5'd29;
    @(negedge clk);
    start = 0;
    check(cos_o == 16'sd9950 && sin_o == 16'sd0, "R7", "initial vector", cos_o, 9950);
    @(negedge clk);
    @(negedge clk);
    check(int'(sin_o) == exp_y2, req, "y after step 2", sin_o, exp_y2);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && cos_o == 0 && sin_o == 0, "R1", "reset state", cos_o, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && cos_o == 0 && sin_o == 0, "R1", "after release", sin_o, 0);

    run_op(0, 29, 0, 1);
    run_op(6434, 29, 0, 1);
    run_op(-6434, 29, 0, 1);
    run_op(9830, 16, 0, 1);
    run_op(-12288, 29, 0, 1);
    run_op(12800, 20, 0, 1);
    run_op(2458, 14, 0, 1);
    run_op(3000, 0, 0, 0);   // clamps to 1
    run_op(-3000, 31, 0, 1); // clamps to 29
    run_op(5000, 1, 0, 0);
    run_op(-7000, 7, 0, 0);
    run_op(4100, 29, 1, 1);  // start pulsed while busy
    run_op(-4100, 12, 1, 0);

    // R10: outputs hold while idle
    begin
      logic signed [15:0] hc, hs;
      hc = cos_o; hs = sin_o;
      repeat (6) @(negedge clk);
      check(cos_o == hc && sin_o == hs, "R10", "hold", cos_o, hc);
    end

    // R5/R6: target equal to entry 0 rotates back, one above rotates on
    two_steps(6434, 4975, "R5");
    two_steps(6435, 14925, "R6");
    two_steps(2458, 4975, "R5");

    // back-to-back: start on the done cycle
    @(negedge clk);
    start = 1; angle_i = 16'sd1000; iter_n = 5'd4;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R2", "done after 4", done, 1);
    start = 1; angle_i = -16'sd1000; iter_n = 5'd5;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R2", "restart on done", busy, 1);
    repeat (8) @(negedge clk);

    finish_run();
  end

endmodule